// File: doc/BRIEF.md
# Secure Read Byte Streamer with Interleaved CRC

This block feeds the byte-output side of a serial memory during a protected read. When a transfer opens, it takes a 15-bit start address and a wrap-mode select. It then fetches bytes from the memory array one at a time and hands each one to the serial shifter over a valid/ready byte handshake. As each byte is accepted, a 16-bit CRC over the group is updated. The CRC is therefore built up during the transfer and never precomputed.

Each group holds 64 data bytes. After the last data byte of a group is accepted, the block sends the two CRC bytes, most significant first, and flags them as check bytes. The CRC of every group is seeded with the address of that group's first byte, so the host can detect both corrupted data and a misplaced address. Streaming continues group after group until chip select goes inactive. A drop of chip select ends the stream at once and discards any partial CRC.

Top module: `sec_rd_streamer`

## Requirements
- R1: While reset is asserted, and afterwards until a stream is opened, out_valid_o and mem_rd_o are 0.
- R2: A start_i pulse with sel_i high in the idle state opens a stream at start_addr_i. Each data byte presented on out_data_o (with out_crc_o = 0) equals the memory byte at the current stream address. The memory is read with mem_rd_o/mem_addr_o and returns data one cycle after the read.
- R3: After each accepted data byte the address advances by one. With page_wrap_i = 1 (latched at start), only the low 6 bits count, so the address wraps inside its 64-byte page. With page_wrap_i = 0, all 15 bits count, and 0x7FFF is followed by 0x0000.
- R4: Exactly 64 data bytes are followed by exactly two bytes with out_crc_o = 1. No check byte appears before the 64th data byte of a group.
- R5: The high check byte comes first, then the low byte. The CRC value follows these rules:
  - generator polynomial 0x1021, start value 0xFFFF, processed MSB first, with no reflection and no final inversion;
  - input sequence: the byte {1'b0, addr[14:8]}, then addr[7:0] of the group's first address, then the group's 64 data bytes in order.
- R6: After the low check byte is accepted, the next group starts at the following address and is seeded with that address.
- R7: While out_valid_o = 1 and out_ready_i = 0 (sel_i high), out_data_o and out_crc_o hold their values and the stream does not advance.
- R8: sel_i low at a clock edge puts the block idle: out_valid_o and mem_rd_o are 0 in the following cycle. A later start opens a fresh group with a fresh seed.
- R9: start_i is ignored while a stream is open; the byte sequence continues unchanged.
- R10: start_i is ignored while sel_i is low; no read or output follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_i | input | 1 | Chip select active (high) |
| start_i | input | 1 | Open a stream (pulse) |
| start_addr_i | input | 15 | First byte address |
| page_wrap_i | input | 1 | 1: wrap within 64-byte page, 0: wrap across array |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 15 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Shifter takes the byte |
| out_data_o | output | 8 | Output byte |
| out_crc_o | output | 1 | Output byte is a check byte |

## Verification
A start sampled at one edge raises mem_rd_o for the next cycle, and the first data byte is valid after the third edge. After an accepted data byte, the next data byte is valid three edges later. The high check byte follows one edge after the 64th data byte is accepted, and the low byte one edge after the high byte. The bench drives inputs and samples outputs on falling edges. It waits for out_valid_o with a bounded poll before comparing each byte with its own CRC and address model. Dropping sel_i is checked exactly one edge later, and stall stability is checked on every held cycle.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LOAD,
    ST_SEND,
    ST_CHK_HI,
    ST_CHK_LO
  } srs_state_e;

endpackage

// File: rtl/srs_crc_byte.sv
module srs_crc_byte #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);

  localparam int PAD_W = CRC_W - 8;

  logic [CRC_W-1:0] stage [0:8];

  assign stage[0] = crc_i ^ {byte_i, {PAD_W{1'b0}}};

  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign stage[g+1] = stage[g][CRC_W-1]
                      ? ({stage[g][CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0])
                      : {stage[g][CRC_W-2:0], 1'b0};
  end

  assign crc_o = stage[8];

endmodule

// File: rtl/srs_addr_step.sv
module srs_addr_step #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              page_wrap_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] FULL_ONE = ADDR_W'(1);

  always_comb begin
    if (page_wrap_i) begin
      addr_o = {addr_i[ADDR_W-1:PAGE_W], addr_i[PAGE_W-1:0] + PAGE_ONE};
    end else begin
      addr_o = addr_i + FULL_ONE;
    end
  end

endmodule

// File: rtl/sec_rd_streamer.sv
module sec_rd_streamer
  import srs_pkg::*;
#(
  parameter int          ADDR_W    = 15,
  parameter int          PAGE_W    = 6,
  parameter int          GROUP_LEN = 64,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              page_wrap_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              out_crc_o
);

  localparam int             CRC_W    = 16;
  localparam int             CNT_W    = $clog2(GROUP_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GROUP_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  srs_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_next, seed_addr;
  logic [CRC_W-1:0]  crc_q, crc_d, data_crc, seed_mid, seed_crc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        byte_q, byte_d;
  logic              wrap_q, wrap_d;
  logic [15:0]       seed_word;

  // seed: CRC of the zero-extended group address, high byte first
  assign seed_addr = (state_q == ST_IDLE) ? start_addr_i : addr_q;

  always_comb begin
    seed_word                = '0;
    seed_word[ADDR_W-1:0]    = seed_addr;
  end

  srs_crc_byte #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_seed_hi (
    .crc_i(CRC_INIT), .byte_i(seed_word[15:8]), .crc_o(seed_mid));

  srs_crc_byte #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_seed_lo (
    .crc_i(seed_mid), .byte_i(seed_word[7:0]), .crc_o(seed_crc));

  srs_crc_byte #(.CRC_W(CRC_W), .POLY(CRC_POLY)) u_data (
    .crc_i(crc_q), .byte_i(byte_q), .crc_o(data_crc));

  srs_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .addr_i(addr_q), .page_wrap_i(wrap_q), .addr_o(addr_next));

  // next state
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    crc_d   = crc_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    wrap_d  = wrap_q;
    if (!sel_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_d  = start_addr_i;
            wrap_d  = page_wrap_i;
            crc_d   = seed_crc;
            cnt_d   = '0;
            state_d = ST_READ;
          end
        end
        ST_READ: state_d = ST_LOAD;
        ST_LOAD: begin
          byte_d  = mem_rdata_i;
          state_d = ST_SEND;
        end
        ST_SEND: begin
          if (out_ready_i) begin
            crc_d  = data_crc;
            addr_d = addr_next;
            if (cnt_q == CNT_LAST) begin
              cnt_d   = '0;
              state_d = ST_CHK_HI;
            end else begin
              cnt_d   = cnt_q + CNT_ONE;
              state_d = ST_READ;
            end
          end
        end
        ST_CHK_HI: begin
          if (out_ready_i) state_d = ST_CHK_LO;
        end
        ST_CHK_LO: begin
          if (out_ready_i) begin
            crc_d   = seed_crc;
            state_d = ST_READ;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      crc_q   <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      wrap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      crc_q   <= crc_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      wrap_q  <= wrap_d;
    end
  end

  // outputs
  assign mem_rd_o    = (state_q == ST_READ);
  assign mem_addr_o  = addr_q;
  assign out_valid_o = (state_q == ST_SEND) || (state_q == ST_CHK_HI) ||
                       (state_q == ST_CHK_LO);
  assign out_crc_o   = (state_q == ST_CHK_HI) || (state_q == ST_CHK_LO);

  always_comb begin
    unique case (state_q)
      ST_CHK_HI: out_data_o = crc_q[15:8];
      ST_CHK_LO: out_data_o = crc_q[7:0];
      default:   out_data_o = byte_q;
    endcase
  end

endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int GROUP_LEN = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic       mem_rd_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_crc_o
);

  localparam int               GC_W   = $clog2(GROUP_LEN + 1);
  localparam logic [GC_W-1:0]  G_FULL = GC_W'(GROUP_LEN);
  localparam logic [GC_W-1:0]  G_ONE  = GC_W'(1);

  logic [GC_W-1:0] data_seen_q;
  logic            half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_seen_q <= '0;
      half_q      <= 1'b0;
    end else if (!sel_i) begin
      data_seen_q <= '0;
      half_q      <= 1'b0;
    end else if (out_valid_o && out_ready_i) begin
      if (!out_crc_o) begin
        data_seen_q <= data_seen_q + G_ONE;
      end else if (half_q) begin
        data_seen_q <= '0;
        half_q      <= 1'b0;
      end else begin
        half_q      <= 1'b1;
      end
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!out_valid_o && !mem_rd_o));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && sel_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_crc_o)));

  a_r8_deselect_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |=> (!out_valid_o && !mem_rd_o));

  a_r4_check_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_crc_o) |-> (data_seen_q == G_FULL));

  a_r4_data_within_group: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_crc_o) |-> (data_seen_q < G_FULL));

endmodule

bind sec_rd_streamer srs_checker #(.GROUP_LEN(GROUP_LEN)) u_srs_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .mem_rd_o(mem_rd_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_crc_o(out_crc_o));

// File: tb/sec_rd_streamer_tb_top.sv
`timescale 1ns/1ps
module sec_rd_streamer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0;
  logic        start_i = 1'b0;
  logic [14:0] start_addr_i = '0;
  logic        page_wrap_i = 1'b0;
  logic        mem_rd_o;
  logic [14:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        out_crc_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  sec_rd_streamer dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .start_i(start_i),
    .start_addr_i(start_addr_i), .page_wrap_i(page_wrap_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_crc_o(out_crc_o));

  function automatic logic [7:0] memf(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= memf(mem_addr_o);

  function automatic logic [15:0] crc_feed(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ b[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [15:0] seed_of(input logic [14:0] a);
    return crc_feed(crc_feed(16'hFFFF, {1'b0, a[14:8]}), a[7:0]);
  endfunction

  function automatic logic [14:0] step_of(input logic [14:0] a, input logic w);
    if (w) return {a[14:6], a[5:0] + 6'd1};
    return a + 15'd1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference stream model
  logic [14:0] m_addr;
  logic [15:0] m_crc;
  logic        m_wrap;
  int          m_cnt;
  int          m_phase;

  task automatic open_stream(input logic [14:0] a, input logic w);
    start_addr_i = a;
    page_wrap_i  = w;
    start_i      = 1'b1;
    @(negedge clk);
    start_i      = 1'b0;
    m_addr = a; m_wrap = w; m_crc = seed_of(a); m_cnt = 0; m_phase = 0;
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 50 && !out_valid_o; t++) @(negedge clk);
  endtask

  task automatic take_next(input string tag);
    logic [7:0] exp_d;
    logic       exp_c;
    wait_valid();
    case (m_phase)
      0:       begin exp_d = memf(m_addr); exp_c = 1'b0; end
      1:       begin exp_d = m_crc[15:8];  exp_c = 1'b1; end
      default: begin exp_d = m_crc[7:0];   exp_c = 1'b1; end
    endcase
    check(out_valid_o && ({out_crc_o, out_data_o} == {exp_c, exp_d}),
          (m_phase == 0) ? tag : "R5 check byte",
          {out_valid_o, out_crc_o, out_data_o}, {1'b1, exp_c, exp_d});
    out_ready_i = 1'b1;
    @(negedge clk);
    out_ready_i = 1'b0;
    if (m_phase == 0) begin
      m_crc  = crc_feed(m_crc, exp_d);
      m_addr = step_of(m_addr, m_wrap);
      m_cnt++;
      if (m_cnt == 64) begin m_phase = 1; m_cnt = 0; end
    end else if (m_phase == 1) begin
      m_phase = 2;
    end else begin
      m_phase = 0;
      m_crc   = seed_of(m_addr);   // R6 reseed
    end
  endtask

  task automatic close_stream();
    sel_i = 1'b0;
    @(negedge clk);
    check(!out_valid_o && !mem_rd_o, "R8 close", {out_valid_o, mem_rd_o}, 0);
    @(negedge clk);
    sel_i = 1'b1;
  endtask

  typedef struct packed {
    logic [14:0] addr;
    logic        wrap;
    logic [7:0]  n;     // handshakes, check bytes included
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{15'h0000, 1'b0, 8'd66},   // R4 R5 aligned single group
    '{15'h0123, 1'b1, 8'd80},   // R3 page wrap 0x13F -> 0x100, R6
    '{15'h7FE0, 1'b0, 8'd100},  // R3 array wrap 0x7FFF -> 0x0000
    '{15'h2A3C, 1'b1, 8'd140},  // R6 two full groups
    '{15'h7FC5, 1'b1, 8'd70}    // R3 page wrap at top page
  };

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= 150000 && !done) begin
        done = 1;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] held_d;
    logic       held_c;
    bit         saw_rd;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!out_valid_o && !mem_rd_o, "R1 in reset", {out_valid_o, mem_rd_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid_o && !mem_rd_o, "R1 idle", {out_valid_o, mem_rd_o}, 0);

    // R10: start with select low
    start_addr_i = 15'h0040; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    saw_rd = 0;
    for (int k = 0; k < 6; k++) begin
      if (mem_rd_o || out_valid_o) saw_rd = 1;
      @(negedge clk);
    end
    check(!saw_rd, "R10 start ignored", saw_rd, 0);

    // table of streams
    sel_i = 1'b1;
    foreach (VECS[v]) begin
      open_stream(VECS[v].addr, VECS[v].wrap);
      for (int i = 0; i < int'(VECS[v].n); i++) take_next($sformatf("R2 R3 vec%0d", v));
      close_stream();
    end

    // R7 stall keeps byte stable
    open_stream(15'h1000, 1'b0);
    wait_valid();
    held_d = out_data_o; held_c = out_crc_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid_o && out_data_o == held_d && out_crc_o == held_c,
            "R7 stall", {out_valid_o, out_crc_o, out_data_o}, {1'b1, held_c, held_d});
    end
    take_next("R7 after stall");

    // R9 start during stream ignored
    start_addr_i = 15'h5555; page_wrap_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 68; i++) take_next("R9 sequence kept");

    // R8 drop select mid-group, then fresh group
    wait_valid();
    sel_i = 1'b0;
    @(negedge clk);
    check(!out_valid_o && !mem_rd_o, "R8 abort", {out_valid_o, mem_rd_o}, 0);
    sel_i = 1'b1;
    open_stream(15'h3F3F, 1'b0);
    for (int i = 0; i < 66; i++) take_next("R8 fresh group");
    close_stream();

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule